// File: doc/BRIEF.md
# Second-level interrupt aggregation controller

This block collects a set of peripheral interrupt lines into a single request toward a parent interrupt controller. Every source is edge-triggered. A rising edge on a source sets that source's pending bit, and the bit stays set until software acknowledges it. Each source also has its own disable bit. The request output is high whenever at least one source is pending and not disabled.

Software reaches the block through a small word-addressed register port. The pending and disable vectors each have three views: a read-only view, a write-one-to-set register and a write-one-to-clear register. A single store can therefore change any chosen group of bits without a read-modify-write sequence. Reads are combinational. Writes take effect at the clock edge on which they are presented, so the new state and the new request level can be seen from the next cycle on. The source inputs must already be synchronous to `clk_i`.

Top module: `irq_gather_ctrl`

## Requirements
- R1: After reset every pending bit is 0, every disable bit is 1 (all sources disabled), and `irq_o` is low.
- R2: A 0-to-1 transition on `src_i[k]` sets pending bit k. Holding the input high does not set the bit again after an acknowledge, and the bit stays set after the input falls.
- R3: A write to byte offset 0x04 sets every pending bit whose data bit is 1 and leaves every other pending bit unchanged.
- R4: A write to byte offset 0x08 clears every pending bit whose data bit is 1 and leaves every other pending bit unchanged.
- R5: A write to offset 0x10 sets the disable bits selected by ones in the data. A write to offset 0x14 clears them. Zero data bits change nothing.
- R6: `irq_o` is high exactly when the pending vector ANDed with the inverted disable vector is nonzero.
- R7: If a rising edge on source k arrives in the same cycle as an acknowledge of bit k, pending bit k ends up set.
- R8: A read (`req_i`=1, `we_i`=0) at offset 0x00 returns the pending vector and at 0x0C returns the disable vector. Reads at 0x04, 0x08, 0x10 and 0x14 return zero.
- R9: Any offset outside {0x00, 0x04, 0x08, 0x0C, 0x10, 0x14} reads as zero, and a write to it changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | N | Peripheral interrupt lines, synchronous to clk_i |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte offset of the register |
| wdata_i | input | N | Write data, one bit per source |
| rdata_o | output | N | Read data (combinational) |
| irq_o | output | 1 | Aggregated request to the parent controller |

## Verification
The bench builds the controller with N = 8 sources instead of the default 32. With eight sources, every one of the 256 patterns can be swept through the pending set and acknowledge paths, through the disable path (each paired with a second pattern), and through the source edge latch. The same-cycle race between an edge and an acknowledge is run for each bit position. All decoded offsets, and a sample of undecoded ones, are covered for both reads and writes.

// File: rtl/irq_gather_pkg.sv
package irq_gather_pkg;
  localparam logic [7:0] OFF_STAT  = 8'h00;
  localparam logic [7:0] OFF_SSET  = 8'h04;
  localparam logic [7:0] OFF_SCLR  = 8'h08;
  localparam logic [7:0] OFF_MSTAT = 8'h0C;
  localparam logic [7:0] OFF_MSET  = 8'h10;
  localparam logic [7:0] OFF_MCLR  = 8'h14;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_STAT, SEL_SSET, SEL_SCLR, SEL_MSTAT, SEL_MSET, SEL_MCLR
  } reg_sel_e;
endpackage

// File: rtl/irq_gather_decode.sv
module irq_gather_decode
  import irq_gather_pkg::*;
#(
  parameter int unsigned N      = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N-1:0]      wdata_i,
  output reg_sel_e          sel_o,
  output logic [N-1:0]      st_set_o,
  output logic [N-1:0]      st_clr_o,
  output logic [N-1:0]      mk_set_o,
  output logic [N-1:0]      mk_clr_o
);
  logic wr;

  always_comb begin
    case (addr_i)
      ADDR_W'(OFF_STAT):  sel_o = SEL_STAT;
      ADDR_W'(OFF_SSET):  sel_o = SEL_SSET;
      ADDR_W'(OFF_SCLR):  sel_o = SEL_SCLR;
      ADDR_W'(OFF_MSTAT): sel_o = SEL_MSTAT;
      ADDR_W'(OFF_MSET):  sel_o = SEL_MSET;
      ADDR_W'(OFF_MCLR):  sel_o = SEL_MCLR;
      default:            sel_o = SEL_NONE;
    endcase
  end

  assign wr       = req_i & we_i;
  assign st_set_o = (wr && sel_o == SEL_SSET) ? wdata_i : '0;
  assign st_clr_o = (wr && sel_o == SEL_SCLR) ? wdata_i : '0;
  assign mk_set_o = (wr && sel_o == SEL_MSET) ? wdata_i : '0;
  assign mk_clr_o = (wr && sel_o == SEL_MCLR) ? wdata_i : '0;
endmodule

// File: rtl/irq_gather_status.sv
module irq_gather_status #(
  parameter int unsigned N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] src_i,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] status_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic prev_q, stat_q, rise;

    assign rise = src_i[i] & ~prev_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prev_q <= 1'b0;
        stat_q <= 1'b0;
      end else begin
        prev_q <= src_i[i];
        // a fresh edge overrides an acknowledge in the same cycle
        stat_q <= rise | set_i[i] | (stat_q & ~clr_i[i]);
      end
    end

    assign status_o[i] = stat_q;
  end
endmodule

// File: rtl/irq_gather_mask.sv
module irq_gather_mask #(
  parameter int unsigned N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] mask_o
);
  logic [N-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= '1;
    else         mask_q <= (mask_q | set_i) & ~clr_i;
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/irq_gather_ctrl.sv
module irq_gather_ctrl
  import irq_gather_pkg::*;
#(
  parameter int unsigned N      = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N-1:0]      src_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N-1:0]      wdata_i,
  output logic [N-1:0]      rdata_o,
  output logic              irq_o
);
  reg_sel_e     sel;
  logic [N-1:0] st_set, st_clr, mk_set, mk_clr;
  logic [N-1:0] status_w, mask_w;

  irq_gather_decode #(.N(N), .ADDR_W(ADDR_W)) u_dec (
    .req_i   (req_i),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .sel_o   (sel),
    .st_set_o(st_set),
    .st_clr_o(st_clr),
    .mk_set_o(mk_set),
    .mk_clr_o(mk_clr)
  );

  irq_gather_status #(.N(N)) u_stat (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .src_i   (src_i),
    .set_i   (st_set),
    .clr_i   (st_clr),
    .status_o(status_w)
  );

  irq_gather_mask #(.N(N)) u_mask (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (mk_set),
    .clr_i (mk_clr),
    .mask_o(mask_w)
  );

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i) begin
      case (sel)
        SEL_STAT:  rdata_o = status_w;
        SEL_MSTAT: rdata_o = mask_w;
        default:   rdata_o = '0;
      endcase
    end
  end

  assign irq_o = |(status_w & ~mask_w);
endmodule

// File: rtl/irq_gather_chk.sv
module irq_gather_chk
  import irq_gather_pkg::*;
#(
  parameter int unsigned N      = 32,
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N-1:0]      src_i,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [N-1:0]      wdata_i,
  input logic [N-1:0]      rdata_o,
  input logic              irq_o,
  input logic [N-1:0]      status_i,
  input logic [N-1:0]      mask_i
);
  logic [N-1:0] src_d, rise;
  logic wr, rd, w_sset, w_sclr, w_mset, w_mclr, known;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) src_d <= '0;
    else         src_d <= src_i;
  end

  assign rise   = src_i & ~src_d;
  assign wr     = req_i & we_i;
  assign rd     = req_i & ~we_i;
  assign w_sset = addr_i == ADDR_W'(OFF_SSET);
  assign w_sclr = addr_i == ADDR_W'(OFF_SCLR);
  assign w_mset = addr_i == ADDR_W'(OFF_MSET);
  assign w_mclr = addr_i == ADDR_W'(OFF_MCLR);
  assign known  = w_sset | w_sclr | w_mset | w_mclr |
                  (addr_i == ADDR_W'(OFF_STAT)) | (addr_i == ADDR_W'(OFF_MSTAT));

  a_r2_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr && w_sclr) |=> (($past(status_i) & ~status_i) == '0));
  a_r2_edge_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(rise) & ~status_i) == '0));
  a_r3_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && w_sset) |=> ((status_i & $past(wdata_i)) == $past(wdata_i)));
  a_r4_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && w_sclr) |=> ((status_i & $past(wdata_i & ~rise)) == '0));
  a_r5_mask_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && w_mset) |=> (mask_i == ($past(mask_i) | $past(wdata_i))));
  a_r5_mask_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && w_mclr) |=> (mask_i == ($past(mask_i) & ~$past(wdata_i))));
  a_r6_irq_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((status_i & ~mask_i) != '0));
  a_r6_irq_lo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> ((status_i & ~mask_i) == '0));
  a_r8_wo_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && (w_sset || w_sclr || w_mset || w_mclr)) |-> (rdata_o == '0));
  a_r9_oor_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && !known) |=> $stable(mask_i));
endmodule

bind irq_gather_ctrl irq_gather_chk #(.N(N), .ADDR_W(ADDR_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .src_i   (src_i),
  .req_i   (req_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .irq_o   (irq_o),
  .status_i(status_w),
  .mask_i  (mask_w)
);

// File: tb/sim_irq_gather_ctrl.sv
module sim_irq_gather_ctrl;
  localparam int unsigned N = 8;
  localparam int unsigned AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  src = '0;
  logic          req = 1'b0;
  logic          we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [N-1:0]  wdata = '0;
  logic [N-1:0]  rdata;
  logic          irq;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  irq_gather_ctrl #(.N(N), .ADDR_W(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic wr(input logic [AW-1:0] a, input logic [N-1:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0; wdata = '0;
  endtask

  task automatic rd_chk(input logic [AW-1:0] a, input logic [N-1:0] exp, input string tag);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    #1;
    n_chk++;
    if (rdata !== exp) begin
      n_bad++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, rdata, exp);
    end
    req = 1'b0;
  endtask

  task automatic irq_chk(input logic exp, input string tag);
    n_chk++;
    if (irq !== exp) begin
      n_bad++;
      $display("FAIL %s irq actual=%b expected=%b", tag, irq, exp);
    end
  endtask

  task automatic set_src(input logic [N-1:0] v);
    @(negedge clk);
    src = v;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    irq_chk(1'b0, "R1");
    rd_chk(8'h00, '0, "R1");
    rd_chk(8'h0C, '1, "R1");

    // R8 write-only offsets read zero
    rd_chk(8'h04, '0, "R8");
    rd_chk(8'h08, '0, "R8");
    rd_chk(8'h10, '0, "R8");
    rd_chk(8'h14, '0, "R8");

    // R3 software set with all sources disabled: pending but no request
    wr(8'h04, 8'hA5);
    rd_chk(8'h00, 8'hA5, "R3");
    irq_chk(1'b0, "R6");
    wr(8'h04, 8'h00);
    rd_chk(8'h00, 8'hA5, "R3");
    wr(8'h08, 8'hFF);

    // R3 R4 R5 R6 exhaustive sweep of pending and disable patterns
    for (int v = 0; v < 256; v++) begin
      logic [N-1:0] p, m;
      p = v[N-1:0];
      m = p ^ 8'h5A;
      wr(8'h14, 8'hFF);
      wr(8'h08, 8'hFF);
      wr(8'h04, p);
      rd_chk(8'h00, p, "R3");
      irq_chk(p != '0, "R6");
      wr(8'h10, m);
      rd_chk(8'h0C, m, "R5");
      irq_chk((p & ~m) != '0, "R6");
      wr(8'h14, m & 8'h0F);
      rd_chk(8'h0C, m & 8'hF0, "R5");
      wr(8'h08, ~p | 8'h33);
      rd_chk(8'h00, p & ~8'h33 & p, "R4");
      irq_chk((p & ~8'h33 & ~(m & 8'hF0)) != '0, "R6");
    end

    // R2 edge latch, stickiness and no re-fire on held level
    wr(8'h14, 8'hFF);
    wr(8'h08, 8'hFF);
    for (int v = 0; v < 256; v++) begin
      logic [N-1:0] p;
      p = v[N-1:0];
      set_src(p);
      set_src('0);
      rd_chk(8'h00, p, "R2");
      irq_chk(p != '0, "R6");
      set_src(p);
      wr(8'h08, 8'hFF);
      rd_chk(8'h00, '0, "R2");
      set_src('0);
      rd_chk(8'h00, '0, "R2");
    end

    // R7 edge in the same cycle as acknowledge
    for (int b = 0; b < N; b++) begin
      wr(8'h04, 8'hFF);
      @(negedge clk);
      src = N'(1) << b;
      req = 1'b1; we = 1'b1; addr = 8'h08; wdata = 8'hFF;
      @(negedge clk);
      req = 1'b0; we = 1'b0; wdata = '0;
      rd_chk(8'h00, N'(1) << b, "R7");
      set_src('0);
      wr(8'h08, 8'hFF);
    end

    // R9 undecoded offsets: reads zero, writes ignored
    wr(8'h10, 8'h0F);
    wr(8'h04, 8'h81);
    for (int a = 0; a < 256; a++) begin
      logic [AW-1:0] aa;
      aa = a[AW-1:0];
      if (aa != 8'h00 && aa != 8'h04 && aa != 8'h08 &&
          aa != 8'h0C && aa != 8'h10 && aa != 8'h14 && (a % 7 == 1)) begin
        wr(aa, 8'hFF);
        rd_chk(aa, '0, "R9");
        rd_chk(8'h00, 8'h81, "R9");
        rd_chk(8'h0C, 8'h0F, "R9");
      end
    end

    // R5 R4 disable all, then acknowledge all
    wr(8'h10, 8'hFF);
    wr(8'h08, 8'hFF);
    rd_chk(8'h0C, 8'hFF, "R5");
    rd_chk(8'h00, 8'h00, "R4");
    irq_chk(1'b0, "R6");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule